// File: doc/BRIEF.md
# Low-Side Driver Channel Fault Supervisor

This block is the digital supervisory logic for one channel of a multi-channel low-side valve driver. It takes the channel enable and input pins plus five comparator flags from the analog front end. The flags report the output voltage below the off-state threshold, the load current below the open-load level, the current above the overload level, the junction above the thermal disable point, and the junction back below the re-enable point. From these it drives the power stage gate enable, a diagnostic level that the host reads as an open-drain signal, and a request to the analog current limiter.

The block evaluates one diagnostic truth table that covers both the on and the off state. It also holds two separate fault latches. The overload latch sets only after overcurrent, or a stored overtemperature with the channel still commanded on, has lasted for a programmable number of clock cycles. The overtemperature latch sets at once and keeps the diagnostic low until the channel input goes low. Thermal disable has hysteresis: it follows the hot flag on the way up and releases only on the cool flag.

All pins and flags are control levels, not a data stream, so no handshake applies at the edge of the block. Every input passes through a two-flop synchronizer. The pads are expected to pull a floating enable or input low, and the synchronizers reset to zero, so the channel is off until the pins are sampled high.

Top module: `lsd_chan_supervisor`

## Requirements
- R1: While the synchronized enable is low, gate_on_o is 0 and diag_ok_o is 0, whatever the input pin and the flags are.
- R2: With enable high and no fault flag, gate_on_o equals the synchronized input and diag_ok_o is 1 in both states.
- R3: In the off state (enable high, input low), a set out_low flag drives diag_ok_o to 0. The i_low flag has no effect in this state.
- R4: In the on state (enable high, input high), a set i_low flag drives diag_ok_o to 0. The out_low flag has no effect in this state.
- R5: While the channel is commanded on and i_over is set, ilim_req_o is 1. If the overload condition holds for OVL_DELAY_CYC consecutive cycles, the overload latch sets. gate_on_o, ilim_req_o and diag_ok_o then go to 0.
- R6: A set t_hot flag turns the gate off. The gate stays off after t_hot clears until t_cool is seen.
- R7: A set t_hot flag also sets the overtemperature latch, which holds diag_ok_o at 0 until the input falls. If the input stays high while this latch is set, the overload latch sets after OVL_DELAY_CYC cycles.
- R8: Each pin or flag change reaches the outputs two clock edges later. During reset all outputs are 0.
- R9: The overload delay count restarts from zero whenever the overload condition drops before the delay expires.
- R10: Both fault latches clear on a falling edge of the synchronized input, or on reset. A normal diagnostic and gate control then return.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| en_pin | input | 1 | Channel enable pin level |
| in_pin | input | 1 | Channel command input pin level |
| out_low_flag | input | 1 | Output voltage below the off-state threshold |
| i_low_flag | input | 1 | Load current below the open-load level |
| i_over_flag | input | 1 | Load current above the overload level |
| t_hot_flag | input | 1 | Junction above the thermal disable point |
| t_cool_flag | input | 1 | Junction below the re-enable point |
| gate_on_o | output | 1 | Power stage gate enable |
| diag_ok_o | output | 1 | Diagnostic level (1 = released high, 0 = pulled low) |
| ilim_req_o | output | 1 | Current-limit request to the analog stage |

## Verification
A wrong fault latch state shows up at the ports within the synchronizer delay. A stuck overload or overtemperature latch keeps diag_ok_o low after the input returns, and the gate stays off on the next on command. A latch that never sets leaves the gate on after the delay window. A delay counter that does not restart, or that is off by one, moves the gate turn-off by at least one cycle, so the gate is checked on both sides of the expiry edge. Thermal hysteresis errors show as the gate coming back on before the cool flag has been seen.

// File: rtl/lsd_pkg.sv
package lsd_pkg;
  typedef struct packed {
    logic en;
    logic in;
    logic out_low;
    logic i_low;
    logic i_over;
    logic t_hot;
    logic t_cool;
  } lsd_in_t;

  localparam int LSD_IN_W = $bits(lsd_in_t);
endpackage

// File: rtl/lsd_sync2.sv
module lsd_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic st1, st2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st1 <= 1'b0;
        st2 <= 1'b0;
      end else begin
        st1 <= d[b];
        st2 <= st1;
      end
    end
    assign q[b] = st2;
  end
endmodule

// File: rtl/lsd_ovl_timer.sv
module lsd_ovl_timer #(
  parameter int DELAY = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic clr,
  output logic ovl_o
);
  localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY);
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic [CW-1:0] cnt;
  logic          ovl;
  logic          run;

  assign run = arm && !ovl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      ovl <= 1'b0;
    end else begin
      if (clr)
        ovl <= 1'b0;
      else if (run && cnt == LAST)
        ovl <= 1'b1;

      if (!run || cnt == LAST)
        cnt <= '0;
      else
        cnt <= cnt + 1'b1;
    end
  end

  assign ovl_o = ovl;

  assert_ovl_after_full_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovl) |-> ($past(cnt) == LAST && $past(arm)));

  assert_count_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !arm |=> (cnt == '0));

  assert_clear_on_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !ovl);
endmodule

// File: rtl/lsd_thermal.sv
module lsd_thermal (
  input  logic clk,
  input  logic rst_n,
  input  logic hot,
  input  logic cool,
  input  logic clr,
  output logic tdis_o,
  output logic otl_o
);
  logic tdis, otl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdis <= 1'b0;
      otl  <= 1'b0;
    end else begin
      if (hot)
        tdis <= 1'b1;
      else if (cool)
        tdis <= 1'b0;

      if (hot)
        otl <= 1'b1;
      else if (clr)
        otl <= 1'b0;
    end
  end

  assign tdis_o = tdis;
  assign otl_o  = otl;

  assert_tdis_on_hot_R6: assert property (@(posedge clk) disable iff (!rst_n)
    hot |=> tdis);

  assert_tdis_holds_until_cool_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tdis && !cool) |=> tdis);

  assert_otl_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (otl && !clr) |=> otl);
endmodule

// File: rtl/lsd_chan_supervisor.sv
module lsd_chan_supervisor
  import lsd_pkg::*;
#(
  parameter int OVL_DELAY_CYC = 40000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_pin,
  input  logic in_pin,
  input  logic out_low_flag,
  input  logic i_low_flag,
  input  logic i_over_flag,
  input  logic t_hot_flag,
  input  logic t_cool_flag,
  output logic gate_on_o,
  output logic diag_ok_o,
  output logic ilim_req_o
);
  lsd_in_t raw, syn;
  logic [LSD_IN_W-1:0] syn_vec;

  assign raw.en      = en_pin;
  assign raw.in      = in_pin;
  assign raw.out_low = out_low_flag;
  assign raw.i_low   = i_low_flag;
  assign raw.i_over  = i_over_flag;
  assign raw.t_hot   = t_hot_flag;
  assign raw.t_cool  = t_cool_flag;

  lsd_sync2 #(.W(LSD_IN_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw),
    .q     (syn_vec)
  );
  assign syn = lsd_in_t'(syn_vec);

  logic in_d, in_fall, drive;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) in_d <= 1'b0;
    else        in_d <= syn.in;
  end
  assign in_fall = in_d && !syn.in;
  assign drive   = syn.en && syn.in;

  logic tdis, otl, ovl;

  lsd_thermal u_thermal (
    .clk    (clk),
    .rst_n  (rst_n),
    .hot    (syn.t_hot),
    .cool   (syn.t_cool),
    .clr    (in_fall),
    .tdis_o (tdis),
    .otl_o  (otl)
  );

  lsd_ovl_timer #(.DELAY(OVL_DELAY_CYC)) u_ovl (
    .clk   (clk),
    .rst_n (rst_n),
    .arm   (drive && (syn.i_over || otl)),
    .clr   (in_fall),
    .ovl_o (ovl)
  );

  assign gate_on_o  = drive && !tdis && !ovl;
  assign ilim_req_o = drive && syn.i_over && !tdis && !ovl;

  always_comb begin
    if (!syn.en)
      diag_ok_o = 1'b0;
    else if (otl || ovl)
      diag_ok_o = 1'b0;
    else if (syn.in)
      diag_ok_o = !syn.i_low;
    else
      diag_ok_o = !syn.out_low;
  end

  assert_en_low_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !syn.en |-> (!gate_on_o && !diag_ok_o));

  assert_ovl_blocks_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ovl |-> (!gate_on_o && !ilim_req_o && !diag_ok_o));

  assert_otl_diag_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    otl |-> !diag_ok_o);

  assert_tdis_blocks_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tdis |-> !gate_on_o);
endmodule

// File: tb/lsd_chan_supervisor_bench.sv
`timescale 1ns/1ps
module lsd_chan_supervisor_bench;
  localparam int D = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_pin = 1'b0, in_pin = 1'b0, out_low_flag = 1'b0, i_low_flag = 1'b0;
  logic i_over_flag = 1'b0, t_hot_flag = 1'b0, t_cool_flag = 1'b0;
  logic gate_on_o, diag_ok_o, ilim_req_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  lsd_chan_supervisor #(.OVL_DELAY_CYC(D)) u_lsd_chan_supervisor (
    .clk(clk), .rst_n(rst_n), .en_pin(en_pin), .in_pin(in_pin),
    .out_low_flag(out_low_flag), .i_low_flag(i_low_flag),
    .i_over_flag(i_over_flag), .t_hot_flag(t_hot_flag), .t_cool_flag(t_cool_flag),
    .gate_on_o(gate_on_o), .diag_ok_o(diag_ok_o), .ilim_req_o(ilim_req_o)
  );

  // vector: {en, in, out_low, i_low, exp_gate, exp_diag}
  localparam logic [5:0] VEC [9] = '{
    6'b0000_00, 6'b0100_00, 6'b0111_00, 6'b1000_01, 6'b1100_11,
    6'b1010_00, 6'b1101_10, 6'b1001_01, 6'b1110_11
  };

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    string rq;
    // R8: reset holds outputs low even with pins high
    en_pin = 1'b1; in_pin = 1'b1;
    waitn(3);
    check("R8", "gate in reset", gate_on_o, 1'b0);
    check("R8", "diag in reset", diag_ok_o, 1'b0);
    check("R8", "ilim in reset", ilim_req_o, 1'b0);
    en_pin = 1'b0; in_pin = 1'b0;
    rst_n = 1'b1;
    waitn(3);

    // truth table walk
    for (int v = 0; v < 9; v++) begin
      {en_pin, in_pin, out_low_flag, i_low_flag} = VEC[v][5:2];
      waitn(3);
      if (!VEC[v][5])                     rq = "R1";
      else if (!VEC[v][4] && VEC[v][3])   rq = "R3";
      else if (VEC[v][4] && VEC[v][2])    rq = "R4";
      else                                rq = "R2";
      check(rq, $sformatf("gate vec%0d", v), gate_on_o, VEC[v][1]);
      check(rq, $sformatf("diag vec%0d", v), diag_ok_o, VEC[v][0]);
    end
    out_low_flag = 1'b0; i_low_flag = 1'b0;

    // R8: two-edge latency
    en_pin = 1'b1; in_pin = 1'b0;
    waitn(3);
    in_pin = 1'b1;
    waitn(1);
    check("R8", "gate after one edge", gate_on_o, 1'b0);
    waitn(1);
    check("R8", "gate after two edges", gate_on_o, 1'b1);

    // R5: overload delay and latch
    i_over_flag = 1'b1;
    waitn(2);
    check("R5", "ilim request", ilim_req_o, 1'b1);
    waitn(D - 1);
    check("R5", "gate before expiry", gate_on_o, 1'b1);
    waitn(1);
    check("R5", "gate after expiry", gate_on_o, 1'b0);
    check("R5", "diag after expiry", diag_ok_o, 1'b0);
    check("R5", "ilim after expiry", ilim_req_o, 1'b0);
    i_over_flag = 1'b0;
    waitn(3);
    check("R5", "latched gate stays off", gate_on_o, 1'b0);
    in_pin = 1'b0;
    waitn(4);
    check("R10", "diag after input fall", diag_ok_o, 1'b1);
    in_pin = 1'b1;
    waitn(3);
    check("R10", "gate after latch clear", gate_on_o, 1'b1);

    // R9: count restarts after a dropout
    i_over_flag = 1'b1;
    waitn(10);
    i_over_flag = 1'b0;
    waitn(5);
    i_over_flag = 1'b1;
    waitn(2 + D - 1);
    check("R9", "gate one cycle before restarted expiry", gate_on_o, 1'b1);
    waitn(1);
    check("R9", "gate at restarted expiry", gate_on_o, 1'b0);
    i_over_flag = 1'b0;
    in_pin = 1'b0;
    waitn(4);
    in_pin = 1'b1;
    waitn(4);
    check("R2", "gate on before thermal", gate_on_o, 1'b1);

    // R6/R7: thermal disable with hysteresis and stored overtemperature
    t_hot_flag = 1'b1;
    waitn(4);
    check("R6", "gate off when hot", gate_on_o, 1'b0);
    check("R7", "diag low when hot", diag_ok_o, 1'b0);
    t_hot_flag = 1'b0;
    waitn(4);
    check("R6", "gate off before cool", gate_on_o, 1'b0);
    t_cool_flag = 1'b1;
    waitn(4);
    check("R6", "gate back after cool", gate_on_o, 1'b1);
    check("R7", "diag still latched low", diag_ok_o, 1'b0);
    waitn(16);
    check("R7", "overload from held overtemp", gate_on_o, 1'b0);
    in_pin = 1'b0;
    waitn(4);
    check("R10", "diag after thermal clear", diag_ok_o, 1'b1);
    in_pin = 1'b1;
    waitn(3);
    check("R10", "gate after thermal clear", gate_on_o, 1'b1);
    check("R10", "diag on after thermal clear", diag_ok_o, 1'b1);
    t_cool_flag = 1'b0;

    // R1: enable low overrides a fault-free on command
    en_pin = 1'b0;
    waitn(3);
    check("R1", "gate with enable low", gate_on_o, 1'b0);
    check("R1", "diag with enable low", diag_ok_o, 1'b0);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule